// File: doc/BRIEF.md
# Programmable 3x3 Mask Filter Engine

This block runs a 3x3 spatial mask over an 8-bit grayscale frame and produces one filtered pixel per source pixel, in raster order. It sits in front of an image scaler and is used twice in a row: once loaded with a weighted smoothing mask to tame aliasing, and once with a high-pass mask to restore edges. The same hardware serves both; only the nine coefficients and a right-shift normalisation amount change.

Incoming pixels are written into a 64-entry buffer. A host writes mask coefficients into a small two-port memory whenever it likes. When a frame is started, a sequencer copies the nine coefficients, one per cycle, from the memory's read port into the working mask, then pulls source rows from the buffer into a three-row store. Once the row below an output row is present, it issues one 3x3 window per cycle to nine parallel multiply lanes. The products are summed, shifted and clamped in a second pipeline stage. At the image border, missing neighbours take the value of the nearest edge pixel, so the output frame has the same size as the input frame.

Top module: `mask_filter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The input buffer holds 64 pixels: after 64 pixels are accepted with none consumed, `in_ready` is 0 and a pixel offered while `in_ready` is 0 is dropped. Accepted pixels are consumed in arrival order, filling the frame row by row, left to right.
- R3: Coefficient address k (0..8) is the tap at mask row k/3 (0 = row above) and mask column k%3 (0 = left neighbour). After reset the memory holds the smoothing mask 1,2,1 / 2,4,2 / 1,2,1. The mask in use is copied when `start` is accepted; writes made later only affect the next frame.
- R4: Each output equals the sum over the nine taps of coefficient (signed two's complement, 8 bits) times pixel (unsigned), arithmetically shifted right by `shift_amt` (0..7, sampled with `start`), then clamped to 0..255.
- R5: A neighbour outside the frame is replaced by the nearest pixel on the frame edge (row and column indices clamped independently); the frame yields IMG_W x IMG_H outputs in raster order.
- R6: Each window reaches `out_valid` two clock edges after it is issued; with a whole frame already buffered and `out_ready` high, the first `out_valid` follows the edge that accepts `start` by 9 + 2*IMG_W + 2 edges (27 for an 8-wide frame).
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_pixel` hold, buffer reads pause, and no result is lost or repeated.
- R8: `start` is ignored while a frame is in progress; once the last output of a frame is accepted, no further output appears without a new `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source pixel offered |
| in_pixel | input | 8 | Source pixel value |
| in_ready | output | 1 | Input buffer has room |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 4 | Coefficient address 0..8 (others ignored) |
| coef_data | input | 8 | Coefficient, signed two's complement |
| shift_amt | input | 3 | Normalisation right shift, sampled with start |
| start | input | 1 | Begin a frame (sampled when idle) |
| out_valid | output | 1 | Filtered pixel available |
| out_pixel | output | 8 | Filtered pixel value |
| out_ready | input | 1 | Downstream accepts the filtered pixel |

## Verification
The first result of a frame is due 27 edges after the edge that accepts `start` when the frame is fully buffered beforehand, so the bench counts falling edges from that point and checks the count. Every later result is due two edges after its window issues, a relation the checker tests against the pipeline's advance signal; the bench does not predict absolute times for these but compares, in raster order, each pixel at the falling edge before the rising edge where `out_valid` and `out_ready` are both high. The idle check after a frame looks at `out_valid` for twenty cycles after the last handshake.

// File: rtl/mask_filter_pkg.sv
package mask_filter_pkg;

    localparam int TAPS = 9;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_KLOAD,
        SEQ_FILL,
        SEQ_EMIT
    } seq_e;

endpackage

// File: rtl/mf_pix_fifo.sv
module mf_pix_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full,
    output logic [AW:0]   count
);
    typedef struct packed {
        logic [AW:0] wr;
        logic [AW:0] rd;
    } ptr_t;

    ptr_t p_d, p_q;
    logic [DW-1:0] mem_q [DEPTH];

    assign count = p_q.wr - p_q.rd;
    assign full  = (count == (AW+1)'(DEPTH));
    assign empty = (count == '0);
    assign dout  = mem_q[p_q.rd[AW-1:0]];

    always_comb begin
        p_d = p_q;
        if (push && !full) p_d.wr = p_q.wr + 1'b1;
        if (pop && !empty) p_d.rd = p_q.rd + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem_q[p_q.wr[AW-1:0]] <= din;
    end
endmodule

// File: rtl/mf_coef_ram.sv
module mf_coef_ram #(
    parameter int CW  = 8,
    parameter int N   = 9,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [CW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [CW-1:0] rdata
);
    logic [CW-1:0] mem_d [N];
    logic [CW-1:0] mem_q [N];

    // reset content: separable 1-2-1 smoothing weights
    function automatic logic [CW-1:0] reset_tap(input int k);
        int wr, wc;
        wr = ((k / 3) == 1) ? 2 : 1;
        wc = ((k % 3) == 1) ? 2 : 1;
        return CW'(wr * wc);
    endfunction

    assign rdata = (raddr < AW'(N)) ? mem_q[raddr] : '0;

    always_comb begin
        for (int i = 0; i < N; i++) mem_d[i] = mem_q[i];
        if (we && (waddr < AW'(N))) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) mem_q[i] <= reset_tap(i);
            else        mem_q[i] <= mem_d[i];
        end
    end
endmodule

// File: rtl/mf_mac_array.sv
module mf_mac_array #(
    parameter int PW = 8,
    parameter int CW = 8,
    parameter int AW = 20,
    parameter int SW = 3,
    parameter int N  = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   adv,
    input  logic                   in_v,
    input  logic [N-1:0][PW-1:0]   taps,
    input  logic [N-1:0][CW-1:0]   coefs,
    input  logic [SW-1:0]          shift,
    output logic                   out_v,
    output logic [PW-1:0]          out_pix
);
    localparam int PRW = PW + CW + 1;
    localparam logic signed [AW-1:0] PMAX = AW'((1 << PW) - 1);

    typedef struct packed {
        logic                  v1;
        logic [SW-1:0]         sh1;
        logic [N-1:0][PRW-1:0] prod;
        logic                  v2;
        logic [PW-1:0]         pix;
    } pipe_t;

    pipe_t s_d, s_q;
    logic signed [PRW-1:0] lane_prod [N];
    logic signed [AW-1:0]  acc;
    logic signed [AW-1:0]  scaled;
    logic [PW-1:0]         clamped;

    // one multiply lane per mask tap
    for (genvar g = 0; g < N; g++) begin : g_lane
        assign lane_prod[g] = $signed({1'b0, taps[g]}) * $signed(coefs[g]);
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < N; i++)
            acc = acc + {{(AW-PRW){s_q.prod[i][PRW-1]}}, s_q.prod[i]};
        scaled = acc >>> s_q.sh1;
        if (scaled < 0)          clamped = '0;
        else if (scaled > PMAX)  clamped = '1;
        else                     clamped = scaled[PW-1:0];
    end

    always_comb begin
        s_d = s_q;
        if (adv) begin
            s_d.v1  = in_v;
            s_d.sh1 = shift;
            for (int i = 0; i < N; i++) s_d.prod[i] = lane_prod[i];
            s_d.v2  = s_q.v1;
            s_d.pix = clamped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_v   = s_q.v2;
    assign out_pix = s_q.pix;
endmodule

// File: rtl/mask_filter.sv
module mask_filter
    import mask_filter_pkg::*;
#(
    parameter int PIX_W      = 8,
    parameter int COEF_W     = 8,
    parameter int ACC_W      = 20,
    parameter int SHIFT_W    = 3,
    parameter int FIFO_DEPTH = 64,
    parameter int IMG_W      = 8,
    parameter int IMG_H      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [PIX_W-1:0]            in_pixel,
    output logic                        in_ready,
    input  logic                        coef_we,
    input  logic [$clog2(TAPS)-1:0]     coef_addr,
    input  logic [COEF_W-1:0]           coef_data,
    input  logic [SHIFT_W-1:0]          shift_amt,
    input  logic                        start,
    output logic                        out_valid,
    output logic [PIX_W-1:0]            out_pixel,
    input  logic                        out_ready
);
    localparam int KA_W = $clog2(TAPS);
    localparam int CX_W = $clog2(IMG_W);
    localparam int RY_W = $clog2(IMG_H);
    localparam int FA_W = $clog2(FIFO_DEPTH);

    typedef struct packed {
        seq_e                                 state;
        logic [KA_W-1:0]                      kidx;
        logic [SHIFT_W-1:0]                   shift;
        logic [TAPS-1:0][COEF_W-1:0]          coef;
        logic [RY_W-1:0]                      lrow;
        logic [RY_W-1:0]                      erow;
        logic [CX_W-1:0]                      col;
        logic [2:0][IMG_W-1:0][PIX_W-1:0]     rows;
    } seq_t;

    seq_t s_d, s_q;

    logic                          adv;
    logic                          win_issue;
    logic                          frame_run;
    logic                          fifo_pop, fifo_empty, fifo_full;
    logic [PIX_W-1:0]              fifo_dout;
    logic [FA_W:0]                 fifo_count;
    logic [COEF_W-1:0]             coef_rd;
    logic [TAPS-1:0][PIX_W-1:0]    taps;

    function automatic logic [1:0] slot_of(input logic [RY_W-1:0] r);
        return 2'(32'(r) % 32'd3);
    endfunction

    function automatic logic [RY_W-1:0] nb_row(input logic [RY_W-1:0] r, input int d);
        if (d < 0) return (r == '0) ? r : r - 1'b1;
        if (d > 0) return (r == RY_W'(IMG_H-1)) ? r : r + 1'b1;
        return r;
    endfunction

    function automatic logic [CX_W-1:0] nb_col(input logic [CX_W-1:0] c, input int d);
        if (d < 0) return (c == '0) ? c : c - 1'b1;
        if (d > 0) return (c == CX_W'(IMG_W-1)) ? c : c + 1'b1;
        return c;
    endfunction

    // whole engine freezes while a finished pixel waits downstream
    assign adv       = !out_valid || out_ready;
    assign win_issue = (s_q.state == SEQ_EMIT);
    assign frame_run = (s_q.state == SEQ_FILL) || (s_q.state == SEQ_EMIT);
    assign fifo_pop  = adv && (s_q.state == SEQ_FILL) && !fifo_empty;

    mf_pix_fifo #(.DW(PIX_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (in_valid),
        .din   (in_pixel),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full),
        .count (fifo_count)
    );
    assign in_ready = !fifo_full;

    mf_coef_ram #(.CW(COEF_W), .N(TAPS)) u_coef (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (coef_we),
        .waddr (coef_addr),
        .wdata (coef_data),
        .raddr (s_q.kidx),
        .rdata (coef_rd)
    );

    // window gather with edge clamping
    always_comb begin
        for (int dy = 0; dy < 3; dy++)
            for (int dx = 0; dx < 3; dx++)
                taps[dy*3+dx] = s_q.rows[slot_of(nb_row(s_q.erow, dy-1))]
                                        [nb_col(s_q.col, dx-1)];
    end

    always_comb begin
        s_d = s_q;
        if (adv) begin
            case (s_q.state)
                SEQ_IDLE: begin
                    if (start) begin
                        s_d.state = SEQ_KLOAD;
                        s_d.kidx  = '0;
                        s_d.shift = shift_amt;
                    end
                end
                SEQ_KLOAD: begin
                    s_d.coef[s_q.kidx] = coef_rd;
                    if (s_q.kidx == KA_W'(TAPS-1)) begin
                        s_d.state = SEQ_FILL;
                        s_d.lrow  = '0;
                        s_d.col   = '0;
                    end else begin
                        s_d.kidx = s_q.kidx + 1'b1;
                    end
                end
                SEQ_FILL: begin
                    if (!fifo_empty) begin
                        s_d.rows[slot_of(s_q.lrow)][s_q.col] = fifo_dout;
                        if (s_q.col == CX_W'(IMG_W-1)) begin
                            s_d.col = '0;
                            if (s_q.lrow == '0) begin
                                s_d.lrow = RY_W'(1);
                            end else begin
                                s_d.state = SEQ_EMIT;
                                s_d.erow  = s_q.lrow - 1'b1;
                            end
                        end else begin
                            s_d.col = s_q.col + 1'b1;
                        end
                    end
                end
                SEQ_EMIT: begin
                    if (s_q.col == CX_W'(IMG_W-1)) begin
                        s_d.col = '0;
                        if (s_q.erow == RY_W'(IMG_H-1)) begin
                            s_d.state = SEQ_IDLE;
                        end else if (s_q.lrow == RY_W'(IMG_H-1)) begin
                            s_d.erow = s_q.erow + 1'b1;
                        end else begin
                            s_d.lrow  = s_q.lrow + 1'b1;
                            s_d.state = SEQ_FILL;
                        end
                    end else begin
                        s_d.col = s_q.col + 1'b1;
                    end
                end
                default: s_d.state = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    mf_mac_array #(
        .PW(PIX_W), .CW(COEF_W), .AW(ACC_W), .SW(SHIFT_W), .N(TAPS)
    ) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .in_v    (win_issue),
        .taps    (taps),
        .coefs   (s_q.coef),
        .shift   (s_q.shift),
        .out_v   (out_valid),
        .out_pix (out_pixel)
    );
endmodule

// File: rtl/mask_filter_chk.sv
module mask_filter_chk #(
    parameter int PIX_W  = 8,
    parameter int NCOEF  = 72,
    parameter int FA_W   = 6,
    parameter int DEPTH  = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PIX_W-1:0] out_pixel,
    input logic             win_issue,
    input logic             adv,
    input logic             frame_run,
    input logic [FA_W:0]    fifo_count,
    input logic [NCOEF-1:0] coef_act
);
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pixel)); // R7

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= (FA_W+1)'(DEPTH)); // R2

    AST_ISSUE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (win_issue && adv) ##1 adv |=> out_valid); // R6

    AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_run |=> $stable(coef_act)); // R3
endmodule

bind mask_filter mask_filter_chk #(
    .PIX_W (PIX_W),
    .NCOEF (9 * COEF_W),
    .FA_W  ($clog2(FIFO_DEPTH)),
    .DEPTH (FIFO_DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_pixel  (out_pixel),
    .win_issue  (win_issue),
    .adv        (adv),
    .frame_run  (frame_run),
    .fifo_count (fifo_count),
    .coef_act   (s_q.coef)
);

// File: tb/mask_filter_test.sv
module mask_filter_test;
    localparam int W = 8;
    localparam int H = 8;
    localparam int NP = W * H;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_pixel = '0;
    logic       in_ready;
    logic       coef_we = 1'b0;
    logic [3:0] coef_addr = '0;
    logic [7:0] coef_data = '0;
    logic [2:0] shift_amt = '0;
    logic       start = 1'b0;
    logic       out_valid;
    logic [7:0] out_pixel;
    logic       out_ready = 1'b1;

    int checks = 0;
    int fails  = 0;
    int img [NP];
    int msk [9];

    always #10 clk = ~clk;

    mask_filter uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_pixel(in_pixel), .in_ready(in_ready),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
        .shift_amt(shift_amt), .start(start),
        .out_valid(out_valid), .out_pixel(out_pixel), .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clampi(input int v, input int hi);
        return (v < 0) ? 0 : ((v > hi) ? hi : v);
    endfunction

    function automatic int golden(input int r, input int c, input int sh);
        int sum = 0;
        int v;
        for (int dy = -1; dy <= 1; dy++)
            for (int dx = -1; dx <= 1; dx++)
                sum += msk[(dy+1)*3 + (dx+1)] *
                       img[clampi(r+dy, H-1)*W + clampi(c+dx, W-1)];
        v = sum >>> sh;
        return clampi(v, 255);
    endfunction

    task automatic write_mask();
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            coef_we = 1'b1; coef_addr = 4'(k); coef_data = 8'(msk[k]);
        end
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    function automatic bit ready_at(input int mode, input int t);
        if (mode == 1) return (t % 3) != 0;
        if (mode == 2) return ((t * 7 + 3) % 5) < 3;
        return 1'b1;
    endfunction

    task automatic run_frame(input int sh, input int mode, input bit lat, input bit poke,
                             input string tag);
        int k, idx, t, exp;
        for (int i = 0; i < NP; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_pixel = 8'(img[i]);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R2 buffer full after 64", int'(in_ready), 0);
        in_valid = 1'b1; in_pixel = 8'hAA;   // offered while full: must be dropped
        @(negedge clk);
        in_valid = 1'b0;
        shift_amt = 3'(sh); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!out_valid && k < 200) begin
            @(negedge clk);
            k++;
        end
        if (lat) chk(k == 9 + 2*W + 2, "R6 first result latency", k, 9 + 2*W + 2);
        idx = 0; t = 0;
        while (idx < NP && t < 5000) begin
            out_ready = ready_at(mode, t);
            if (poke) begin
                coef_we = (t == 10); coef_addr = 4'd4; coef_data = 8'd100;
                start   = (t == 10);
            end
            if (out_valid && out_ready) begin
                exp = golden(idx / W, idx % W, sh);
                chk(int'(out_pixel) == exp, tag, int'(out_pixel), exp);
                idx++;
            end
            @(negedge clk);
            t++;
        end
        coef_we = 1'b0; start = 1'b0; out_ready = 1'b1;
        chk(idx == NP, "R5 output count", idx, NP);
        chk(in_ready == 1'b1, "R2 buffer drained", int'(in_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        bit quiet;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid at reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready at reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset mask (smoothing), R4/R5 on a ramp, R6 latency
        msk = '{1, 2, 1, 2, 4, 2, 1, 2, 1};
        for (int i = 0; i < NP; i++) img[i] = ((i / W) * 30 + (i % W) * 7) % 256;
        run_frame(4, 0, 1'b1, 1'b0, "R3 reset smoothing mask");

        // R4 sharpening with saturation at both ends, R7 stalls
        msk = '{0, -1, 0, -1, 5, -1, 0, -1, 0};
        write_mask();
        for (int i = 0; i < NP; i++) img[i] = (((i / W) + (i % W)) % 2 == 0) ? 255 : 0;
        img[0] = 17; img[NP-1] = 200;
        run_frame(0, 1, 1'b0, 1'b0, "R7 sharpen with stalls");

        // R4 sweep over every shift with wide signed coefficients
        for (int sh = 0; sh < 8; sh++) begin
            for (int k = 0; k < 9; k++) msk[k] = ((k * 53 + sh * 29) % 256) - 128;
            msk[sh] = (sh % 2 == 0) ? 127 : -128;
            write_mask();
            for (int i = 0; i < NP; i++) img[i] = (i * 73 + 11 + sh * 17) % 256;
            run_frame(sh, 2, 1'b1, 1'b0, "R4 shift sweep");
        end

        // R8 start ignored mid-frame; R3 mid-frame write deferred
        msk = '{1, 1, 1, 1, 1, 1, 1, 1, 1};
        write_mask();
        for (int i = 0; i < NP; i++) img[i] = (i * 29 + 5) % 256;
        run_frame(3, 1, 1'b0, 1'b1, "R3 mask frozen during frame");
        quiet = 1'b1;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            if (out_valid) quiet = 1'b0;
        end
        chk(quiet, "R8 no output after frame end", int'(quiet), 1);

        // R3 the deferred write applies to the next frame
        msk[4] = 100;
        for (int i = 0; i < NP; i++) img[i] = (i * 41 + 90) % 256;
        run_frame(5, 0, 1'b1, 1'b0, "R3 deferred write in next frame");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule